// File: doc/BRIEF.md
# Single-Channel Basic-Mode DMA Engine

This block moves a programmed run of data items for one DMA channel. On a start pulse it reads the channel's three-word descriptor from a control table in memory. The first word is the inclusive last source address, the second is the inclusive last destination address, and the third is the control word. If the descriptor selects basic mode, the engine then waits for peripheral requests. Each admitted request moves items one at a time: one read followed by one write on a single memory port. Every address is derived backwards from the end pointers.

Four per-channel attributes are held in a small set/clear register bank: priority, alternate descriptor, burst-only and request mask. The engine gives up the memory port after every group of 2^ARB items and waits for a fresh request. After the last item it writes back a stopped control word and pulses `done`.

The memory port is a request channel plus a read-return strobe. A request (`m_valid` with address, size, write flag and write data) is taken on a cycle where `m_ready` is also high. While `m_ready` is low the engine holds every request field unchanged. Read data returns on a later cycle, flagged by `r_valid`. The engine keeps at most one read outstanding and always accepts the returned data, so the return path has no back-pressure.

Top module: `dmab_chan_engine`

## Requirements
- R1: The attribute bits are indexed as follows: 0 priority, 1 alternate descriptor, 2 burst-only, 3 request mask. All four reset to 0. A 1 on `attr_set[i]` sets bit i and a 1 on `attr_clr[i]` clears it, with clear winning when both are high. A 0 on either input leaves the bit unchanged. `attr_q` shows the bits one cycle after the write.
- R2: The descriptor lives at `tbl_base + 16*CHAN`, or at `tbl_base + ALT_OFS + 16*CHAN` when the alternate bit is set at start. It is read as three words at offsets +0, +4 and +8, in that order.
- R3: The control word fields are: destination increment [31:30], destination size [29:28], source increment [27:26], source size [25:24], arbitration exponent ARB [17:14], count-minus-one [13:4] and mode [2:0]. Only mode 1 runs a transfer. Any other mode returns the engine to idle with no item moved, no write-back and no `done`.
- R4: The run moves count-minus-one + 1 items. Item k, counted from 0, is read at `src_end - (N-1-k)*2^sinc` and written at `dst_end - (N-1-k)*2^dinc`, with items in ascending k. An increment code of 3 keeps the address fixed. Size codes 0, 1 and 2 mean 1, 2 and 4 bytes and appear on `m_size`.
- R5: A request is ignored while the mask bit is set. While the burst-only bit is set, `req_single` is ignored. An admitted burst request moves up to 2^ARB items. An admitted single request moves exactly one item.
- R6: `bus_own` drops after the descriptor fetch and after each group of 2^ARB items. A new request is then needed to continue. `m_valid` is never high while `bus_own` is low.
- R7: After the last item the engine writes the control word back to descriptor +8 with bits [13:4] and [2:0] cleared. `done` is high for exactly one cycle, in the cycle after that write is accepted. A last item that ends a group needs no further request.
- R8: While `m_valid` is high and `m_ready` is low, the engine holds `m_addr`, `m_write`, `m_size` and `m_wdata` stable.
- R9: After reset `busy`, `bus_own`, `m_valid` and `done` are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| tbl_base | input | AW | Control table base address |
| start | input | 1 | Begin a descriptor fetch when idle |
| attr_set | input | 4 | Attribute set strobes |
| attr_clr | input | 4 | Attribute clear strobes |
| attr_q | output | 4 | Attribute bits |
| req_single | input | 1 | Single-item peripheral request |
| req_burst | input | 1 | Burst peripheral request |
| m_valid | output | 1 | Memory request valid |
| m_ready | input | 1 | Memory request accepted |
| m_write | output | 1 | Request is a write |
| m_addr | output | AW | Request byte address |
| m_size | output | 2 | Access size code |
| m_wdata | output | DW | Write data |
| r_valid | input | 1 | Read data valid |
| r_data | input | DW | Read data |
| bus_own | output | 1 | Engine holds the memory port |
| busy | output | 1 | Engine not idle |
| done | output | 1 | One-cycle completion pulse |

## Verification
Two events can land in the same cycle: the final item of a run and the end of an arbitration group. They coincide when N equals 2^ARB. The bench provokes this with four items and ARB 2, admitted by a single burst pulse. The design must go straight to the write-back rather than park for another request. This is judged by `done` arriving with all four items logged and `bus_own` falling exactly twice. A second collision is between a set and a clear on the same attribute in one cycle, where the bit must read back cleared.

// File: rtl/dmab_pkg.sv
package dmab_pkg;
  localparam int unsigned ATTR_PRIO = 0;
  localparam int unsigned ATTR_ALT  = 1;
  localparam int unsigned ATTR_UB   = 2;
  localparam int unsigned ATTR_MASK = 3;
  localparam int unsigned NATTR     = 4;

  typedef struct packed {
    logic [1:0] dinc;
    logic [1:0] dsize;
    logic [1:0] sinc;
    logic [1:0] ssize;
    logic [5:0] rsvd;
    logic [3:0] arb;
    logic [9:0] cnt;
    logic       nub;
    logic [2:0] mode;
  } ctl_t;

  typedef enum logic [2:0] {
    S_IDLE, S_FREQ, S_FWAIT, S_ARB, S_RREQ, S_RWAIT, S_WREQ, S_WB
  } st_e;

  localparam logic [2:0] MODE_BASIC = 3'd1;
endpackage

// File: rtl/dmab_attr_regs.sv
module dmab_attr_regs #(
  parameter int unsigned N = 4
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [N-1:0] set_i,
  input  logic [N-1:0] clr_i,
  output logic [N-1:0] q_o
);
  for (genvar i = 0; i < N; i++) begin : g_bit
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)        q_o[i] <= 1'b0;
      else if (clr_i[i]) q_o[i] <= 1'b0;
      else if (set_i[i]) q_o[i] <= 1'b1;
    end
  end
endmodule

// File: rtl/dmab_addr_gen.sv
module dmab_addr_gen #(
  parameter int unsigned AW = 32,
  parameter int unsigned CW = 10
) (
  input  logic [AW-1:0] end_i,
  input  logic [1:0]    inc_i,
  input  logic [CW-1:0] rem_i,
  output logic [AW-1:0] addr_o
);
  logic [AW-1:0] back;
  always_comb begin
    back   = {{(AW-CW){1'b0}}, rem_i} << inc_i;
    addr_o = (inc_i == 2'd3) ? end_i : end_i - back;
  end
endmodule

// File: rtl/dmab_chan_engine.sv
module dmab_chan_engine
  import dmab_pkg::*;
#(
  parameter int unsigned AW      = 32,
  parameter int unsigned DW      = 32,
  parameter int unsigned CHAN    = 7,
  parameter int unsigned ALT_OFS = 32'h200,
  parameter int unsigned GW      = 16
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic [AW-1:0] tbl_base,
  input  logic          start,
  input  logic [3:0]    attr_set,
  input  logic [3:0]    attr_clr,
  output logic [3:0]    attr_q,
  input  logic          req_single,
  input  logic          req_burst,
  output logic          m_valid,
  input  logic          m_ready,
  output logic          m_write,
  output logic [AW-1:0] m_addr,
  output logic [1:0]    m_size,
  output logic [DW-1:0] m_wdata,
  input  logic          r_valid,
  input  logic [DW-1:0] r_data,
  output logic          bus_own,
  output logic          busy,
  output logic          done
);
  localparam int unsigned CW = 10;
  localparam logic [AW-1:0] CH_OFS  = AW'(CHAN * 16);
  localparam logic [AW-1:0] ALT_ADD = AW'(ALT_OFS);

  st_e           st;
  logic [1:0]    fidx;
  logic [AW-1:0] s_base, src_end, dst_end, src_addr, dst_addr;
  ctl_t          ctl, wb_word;
  logic [CW-1:0] rem;
  logic [GW-1:0] grp;
  logic [DW-1:0] dbuf;
  logic          hs, burst_ok, single_ok;

  dmab_attr_regs #(.N(NATTR)) u_attr (
    .clk(clk), .rst_n(rst_n), .set_i(attr_set), .clr_i(attr_clr), .q_o(attr_q)
  );

  dmab_addr_gen #(.AW(AW), .CW(CW)) u_src_ag (
    .end_i(src_end), .inc_i(ctl.sinc), .rem_i(rem), .addr_o(src_addr)
  );
  dmab_addr_gen #(.AW(AW), .CW(CW)) u_dst_ag (
    .end_i(dst_end), .inc_i(ctl.dinc), .rem_i(rem), .addr_o(dst_addr)
  );

  always_comb begin
    wb_word      = ctl;
    wb_word.cnt  = '0;
    wb_word.mode = '0;
  end

  assign burst_ok  = !attr_q[ATTR_MASK] && req_burst;
  assign single_ok = !attr_q[ATTR_MASK] && !attr_q[ATTR_UB] && req_single;

  always_comb begin
    m_valid = 1'b0;
    m_write = 1'b0;
    m_addr  = '0;
    m_size  = 2'd2;
    m_wdata = '0;
    unique case (st)
      S_FREQ: begin
        m_valid = 1'b1;
        m_addr  = s_base + AW'({fidx, 2'b00});
      end
      S_RREQ: begin
        m_valid = 1'b1;
        m_addr  = src_addr;
        m_size  = ctl.ssize;
      end
      S_WREQ: begin
        m_valid = 1'b1;
        m_write = 1'b1;
        m_addr  = dst_addr;
        m_size  = ctl.dsize;
        m_wdata = dbuf;
      end
      S_WB: begin
        m_valid = 1'b1;
        m_write = 1'b1;
        m_addr  = s_base + AW'(8);
        m_wdata = DW'(wb_word);
      end
      default: ;
    endcase
  end

  assign hs      = m_valid && m_ready;
  assign busy    = (st != S_IDLE);
  assign bus_own = busy && (st != S_ARB);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st      <= S_IDLE;
      fidx    <= '0;
      s_base  <= '0;
      src_end <= '0;
      dst_end <= '0;
      ctl     <= '0;
      rem     <= '0;
      grp     <= '0;
      dbuf    <= '0;
      done    <= 1'b0;
    end else begin
      done <= 1'b0;
      unique case (st)
        S_IDLE: if (start) begin
          s_base <= tbl_base + (attr_q[ATTR_ALT] ? ALT_ADD : '0) + CH_OFS;
          fidx   <= '0;
          st     <= S_FREQ;
        end
        S_FREQ: if (hs) st <= S_FWAIT;
        S_FWAIT: if (r_valid) begin
          unique case (fidx)
            2'd0:    src_end <= r_data[AW-1:0];
            2'd1:    dst_end <= r_data[AW-1:0];
            default: begin
              ctl <= ctl_t'(r_data[31:0]);
              rem <= r_data[13:4];
            end
          endcase
          if (fidx == 2'd2)
            st <= (r_data[2:0] == MODE_BASIC) ? S_ARB : S_IDLE;
          else begin
            fidx <= fidx + 2'd1;
            st   <= S_FREQ;
          end
        end
        S_ARB: if (burst_ok || single_ok) begin
          grp <= burst_ok ? (GW'(1) << ctl.arb) - GW'(1) : '0;
          st  <= S_RREQ;
        end
        S_RREQ: if (hs) st <= S_RWAIT;
        S_RWAIT: if (r_valid) begin
          dbuf <= r_data;
          st   <= S_WREQ;
        end
        S_WREQ: if (hs) begin
          if (rem == '0) st <= S_WB;
          else begin
            rem <= rem - CW'(1);
            if (grp == '0) st <= S_ARB;
            else begin
              grp <= grp - GW'(1);
              st  <= S_RREQ;
            end
          end
        end
        S_WB: if (hs) begin
          done <= 1'b1;
          st   <= S_IDLE;
        end
        default: st <= S_IDLE;
      endcase
    end
  end
endmodule

// File: rtl/dmab_chan_engine_chk.sv
module dmab_chan_engine_chk #(
  parameter int unsigned AW = 32,
  parameter int unsigned DW = 32
) (
  input logic          clk,
  input logic          rst_n,
  input logic [3:0]    attr_set,
  input logic [3:0]    attr_clr,
  input logic [3:0]    attr_q,
  input logic          m_valid,
  input logic          m_ready,
  input logic          m_write,
  input logic [AW-1:0] m_addr,
  input logic [1:0]    m_size,
  input logic [DW-1:0] m_wdata,
  input logic          bus_own,
  input logic          done
);
  AST_SET_TAKES: assert property (@(posedge clk) disable iff (!rst_n)
    ((attr_set & ~attr_clr) != 4'd0) |=>
      ((attr_q & $past(attr_set & ~attr_clr)) == $past(attr_set & ~attr_clr))); // R1
  AST_CLR_TAKES: assert property (@(posedge clk) disable iff (!rst_n)
    (attr_clr != 4'd0) |=> ((attr_q & $past(attr_clr)) == 4'd0)); // R1
  AST_NO_REQ_RELEASED: assert property (@(posedge clk) disable iff (!rst_n)
    !bus_own |-> !m_valid); // R6
  AST_DONE_ONE_CYCLE: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done); // R7
  AST_DONE_AFTER_WB: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> $past(m_valid && m_ready && m_write)); // R7
  AST_REQ_HELD: assert property (@(posedge clk) disable iff (!rst_n)
    (m_valid && !m_ready) |=> (m_valid && $stable(m_addr) && $stable(m_write)
                               && $stable(m_size) && $stable(m_wdata))); // R8
endmodule

bind dmab_chan_engine dmab_chan_engine_chk #(.AW(AW), .DW(DW)) u_chk (
  .clk(clk), .rst_n(rst_n), .attr_set(attr_set), .attr_clr(attr_clr),
  .attr_q(attr_q), .m_valid(m_valid), .m_ready(m_ready), .m_write(m_write),
  .m_addr(m_addr), .m_size(m_size), .m_wdata(m_wdata), .bus_own(bus_own),
  .done(done)
);

// File: tb/dmab_chan_engine_tb.sv
module dmab_chan_engine_tb;
  localparam logic [31:0] TBL = 32'h400;
  localparam logic [31:0] DESC = TBL + 32'h70;
  localparam logic [31:0] ADESC = TBL + 32'h200 + 32'h70;
  localparam logic [31:0] PER = 32'hF00;

  logic clk = 0, rst_n = 0, start = 0, req_single = 0, req_burst = 0;
  logic [3:0] attr_set = 0, attr_clr = 0, attr_q;
  logic m_valid, m_ready = 0, m_write, r_valid = 0, bus_own, busy, done;
  logic [31:0] m_addr, m_wdata, r_data = 0;
  logic [1:0] m_size;

  logic [7:0]  mem [0:4095];
  logic [31:0] plog [0:63];
  int pn = 0, falls = 0, dones = 0, tests = 0, fails = 0, cyc = 0;
  bit prev_own = 0;

  always #2 clk = ~clk;

  dmab_chan_engine u_dut (
    .clk(clk), .rst_n(rst_n), .tbl_base(TBL), .start(start),
    .attr_set(attr_set), .attr_clr(attr_clr), .attr_q(attr_q),
    .req_single(req_single), .req_burst(req_burst), .m_valid(m_valid),
    .m_ready(m_ready), .m_write(m_write), .m_addr(m_addr), .m_size(m_size),
    .m_wdata(m_wdata), .r_valid(r_valid), .r_data(r_data), .bus_own(bus_own),
    .busy(busy), .done(done)
  );

  function automatic logic [31:0] rd(logic [31:0] a, logic [1:0] sz);
    logic [11:0] i = a[11:0];
    if (sz == 2'd0) return {24'd0, mem[i]};
    if (sz == 2'd1) return {16'd0, mem[i+12'd1], mem[i]};
    return {mem[i+12'd3], mem[i+12'd2], mem[i+12'd1], mem[i]};
  endfunction

  task automatic put_word(logic [31:0] a, logic [31:0] v);
    for (int b = 0; b < 4; b++) mem[a[11:0] + 12'(b)] = v[8*b +: 8];
  endtask

  function automatic logic [31:0] mk_ctl(int di, int ds, int si, int ss, int arb, int cnt, int mode);
    return {2'(di), 2'(ds), 2'(si), 2'(ss), 6'd0, 4'(arb), 10'(cnt), 1'b0, 3'(mode)};
  endfunction

  // memory model with periodic back-pressure
  initial forever begin
    @(posedge clk);
    cyc++;
    if (m_valid && m_ready) begin
      if (m_write) begin
        for (int b = 0; b < 4; b++)
          if (b < (1 << m_size)) mem[m_addr[11:0] + 12'(b)] <= m_wdata[8*b +: 8];
        if (m_addr == PER) begin plog[pn] <= m_wdata & 32'hFF; pn <= pn + 1; end
        r_valid <= 1'b0;
      end else begin
        r_valid <= 1'b1;
        r_data  <= rd(m_addr, m_size);
      end
    end else r_valid <= 1'b0;
    m_ready <= (cyc % 3) != 2;
  end

  initial forever begin
    @(negedge clk);
    if (prev_own && !bus_own) falls++;
    if (done) dones++;
    prev_own = bus_own;
  end

  task automatic chk(string req, logic [31:0] act, logic [31:0] exp);
    tests++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic kick();
    @(negedge clk); start = 1;
    @(negedge clk); start = 0;
  endtask

  task automatic wait_done(int d0, int maxc);
    for (int i = 0; i < maxc && dones == d0; i++) @(negedge clk);
  endtask

  task automatic wait_park();
    for (int i = 0; i < 200 && !bus_own; i++) @(negedge clk);
    for (int i = 0; i < 200 && bus_own; i++) @(negedge clk);
  endtask

  task automatic pulse(bit burst);
    @(negedge clk); if (burst) req_burst = 1; else req_single = 1;
    @(negedge clk); req_burst = 0; req_single = 0;
  endtask

  task automatic attr_wr(logic [3:0] s, logic [3:0] c);
    @(negedge clk); attr_set = s; attr_clr = c;
    @(negedge clk); attr_set = 0; attr_clr = 0;
  endtask

  task automatic t_reset();
    chk("R9 busy", busy, 0); chk("R9 bus_own", bus_own, 0);
    chk("R9 m_valid", m_valid, 0); chk("R9 done", done, 0);
    chk("R1 reset attr", attr_q, 4'h0);
  endtask

  task automatic t_attr();
    attr_wr(4'b0101, 4'b0000); chk("R1 set", attr_q, 4'b0101);
    attr_wr(4'b0000, 4'b0000); chk("R1 zero no effect", attr_q, 4'b0101);
    attr_wr(4'b0010, 4'b0100); chk("R1 set/clear", attr_q, 4'b0011);
    attr_wr(4'b0001, 4'b0001); chk("R1 clear wins", attr_q, 4'b0010);
    attr_wr(4'b0000, 4'b0010); chk("R1 clear", attr_q, 4'b0000);
  endtask

  task automatic t_bytes_to_periph();
    int p0 = pn, d0 = dones;
    for (int i = 0; i < 8; i++) mem[12'h100 + 12'(i)] = 8'hA0 + 8'(i);
    put_word(DESC, 32'h107); put_word(DESC + 4, PER);
    put_word(DESC + 8, mk_ctl(3, 0, 0, 0, 1, 7, 1));
    falls = 0; req_burst = 1;
    kick(); wait_done(d0, 2000); req_burst = 0;
    chk("R7 done seen", dones - d0, 1);
    chk("R4 item count", pn - p0, 8);
    for (int i = 0; i < 8; i++) chk("R4 byte order", plog[p0 + i], 32'hA0 + i);
    chk("R6 releases", falls, 5);
    chk("R7 writeback", rd(DESC + 8, 2), mk_ctl(3, 0, 0, 0, 1, 0, 0));
  endtask

  task automatic t_halfwords();
    int d0 = dones;
    for (int i = 0; i < 5; i++) begin
      mem[12'h200 + 12'(2*i)] = 8'(8'h11 * (i + 1));
      mem[12'h201 + 12'(2*i)] = 8'(8'h22 * (i + 1));
      mem[12'h300 + 12'(2*i)] = 0; mem[12'h301 + 12'(2*i)] = 0;
    end
    put_word(DESC, 32'h208); put_word(DESC + 4, 32'h308);
    put_word(DESC + 8, mk_ctl(1, 1, 1, 1, 3, 4, 1));
    req_burst = 1; kick(); wait_done(d0, 2000); req_burst = 0;
    for (int i = 0; i < 5; i++)
      chk("R4 halfword copy", rd(32'h300 + 32'(2*i), 1),
          {16'd0, 8'(8'h22 * (i + 1)), 8'(8'h11 * (i + 1))});
  endtask

  task automatic t_mode0();
    int p0 = pn, d0 = dones;
    put_word(DESC, 32'h107); put_word(DESC + 4, PER);
    put_word(DESC + 8, mk_ctl(3, 0, 0, 0, 1, 3, 0));
    req_burst = 1; kick(); repeat (60) @(negedge clk); req_burst = 0;
    chk("R3 no done", dones - d0, 0); chk("R3 no items", pn - p0, 0);
    chk("R3 idle", busy, 0);
    chk("R3 no writeback", rd(DESC + 8, 2), mk_ctl(3, 0, 0, 0, 1, 3, 0));
  endtask

  task automatic t_mask();
    int p0 = pn, d0 = dones;
    put_word(DESC, 32'h101); put_word(DESC + 4, PER);
    put_word(DESC + 8, mk_ctl(3, 0, 0, 0, 2, 1, 1));
    attr_wr(4'b1000, 0);
    req_burst = 1; kick(); repeat (60) @(negedge clk);
    chk("R5 mask blocks", pn - p0, 0); chk("R5 mask waits", busy, 1);
    attr_wr(0, 4'b1000); wait_done(d0, 2000); req_burst = 0;
    chk("R5 unmask runs", pn - p0, 2);
  endtask

  task automatic t_burst_only();
    int p0 = pn, d0 = dones;
    put_word(DESC, 32'h102); put_word(DESC + 4, PER);
    put_word(DESC + 8, mk_ctl(3, 0, 0, 0, 2, 2, 1));
    attr_wr(4'b0100, 0);
    kick(); wait_park();
    req_single = 1; repeat (30) @(negedge clk); req_single = 0;
    chk("R5 single ignored", pn - p0, 0);
    pulse(1); wait_done(d0, 2000);
    chk("R5 burst accepted", pn - p0, 3);
    attr_wr(0, 4'b0100);
  endtask

  task automatic t_single();
    int p0 = pn, d0 = dones;
    put_word(DESC, 32'h102); put_word(DESC + 4, PER);
    put_word(DESC + 8, mk_ctl(3, 0, 0, 0, 2, 2, 1));
    kick(); wait_park();
    pulse(0); repeat (40) @(negedge clk);
    chk("R5 single moves one", pn - p0, 1); chk("R5 not done", dones - d0, 0);
    pulse(0); repeat (40) @(negedge clk);
    chk("R5 second single", pn - p0, 2);
    pulse(0); wait_done(d0, 2000);
    chk("R5 third single ends", pn - p0, 3);
  endtask

  task automatic t_boundary_end();
    int p0 = pn, d0 = dones;
    put_word(DESC, 32'h103); put_word(DESC + 4, PER);
    put_word(DESC + 8, mk_ctl(3, 0, 0, 0, 2, 3, 1));
    falls = 0; kick(); wait_park(); pulse(1); wait_done(d0, 2000);
    chk("R7 last item at boundary", dones - d0, 1);
    chk("R7 items", pn - p0, 4);
    chk("R6 falls at end", falls, 2);
  endtask

  task automatic t_alt();
    int d0 = dones;
    for (int i = 0; i < 3; i++) put_word(32'h500 + 32'(4*i), 32'hC0DE0000 + i);
    put_word(ADESC, 32'h508); put_word(ADESC + 4, 32'h588);
    put_word(ADESC + 8, mk_ctl(2, 2, 2, 2, 0, 2, 1));
    put_word(DESC + 8, 32'h0);
    attr_wr(4'b0010, 0);
    falls = 0; req_burst = 1; kick(); wait_done(d0, 2000); req_burst = 0;
    chk("R2 alt descriptor used", dones - d0, 1);
    for (int i = 0; i < 3; i++)
      chk("R4 word copy", rd(32'h580 + 32'(4*i), 2), 32'hC0DE0000 + i);
    chk("R6 group of one", falls, 4);
    chk("R7 alt writeback", rd(ADESC + 8, 2), mk_ctl(2, 2, 2, 2, 0, 0, 0));
    attr_wr(0, 4'b0010);
  endtask

  initial begin
    for (int i = 0; i < 4096; i++) mem[i] = 0;
    repeat (3) @(negedge clk);
    t_reset();
    rst_n = 1;
    repeat (2) @(negedge clk);
    t_attr();
    t_bytes_to_periph();
    t_halfwords();
    t_mode0();
    t_mask();
    t_burst_only();
    t_single();
    t_boundary_end();
    t_alt();
    $display("  [TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

  initial begin
    #(4 * 150000);
    tests++; fails++;
    $display("FAIL watchdog expired");
    $display("  [TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule